// File: doc/BRIEF.md
# Weighted Round-Robin Arbiter with Priority Masters

This block decides which of several bus masters may use one shared slave port. A small group of processor masters always wins over every other master. Among processor masters, the lowest index wins. The other masters share whatever bandwidth the processors leave by weighted round robin. Each of those masters has a programmable weight. The weight is the number of consecutive transfers the master may make before the grant moves on. A master that holds a locked sequence keeps the port until it releases the lock.

The grant is registered. It moves only at a transfer boundary, which the surrounding bus logic signals on `xfer_end`, or while no master holds the port. New weights are captured on a load strobe. They become active only after the bus has been free of requests for a fixed window of cycles, so that no transfer is in flight when the weights change. A one-cycle flag reports the moment the new weights take effect.

Top module: `wrr_prio_arbiter`

## Requirements
- R1: While `rst_n` is low, and directly after reset, `grant` is all zero and `cfg_ok` is low. Every round-robin weight resets to `RST_WEIGHT`, which defaults to 1. The round-robin pointer resets so that round-robin master 0 is tried first.
- R2: `grant` is always either all zero or one-hot. Bits 0 to `N_PRIO-1` are the processor masters. Bit `N_PRIO+k` is round-robin master k.
- R3: When a clock edge is an arbitration point and any processor master requests, the grant goes to the lowest-index requesting processor master. This holds even if it means round-robin masters are starved indefinitely. The only exception is a locked holder (R7).
- R4: A round-robin master that receives the grant with weight W keeps it for W consecutive arbitration points. It must keep requesting and no processor master may request. At the next arbitration point after that, the grant rotates. The weight counter reloads each time the grant moves to a round-robin master.
- R5: The rotation search starts at the round-robin index after the last granted one and goes up in index order. It wraps to index 0 and skips masters that are not requesting. It returns to the same master only if no other master requests.
- R6: A weight value of 0 behaves as a weight of 1.
- R7: A granted master whose `lock` and `req` bits are both high keeps the grant at every arbitration point. This holds against processor requests and when its weight is used up.
- R8: An arbitration point is a clock edge at which `xfer_end` is high or `grant` is zero. At any other edge `grant` does not change.
- R9: At an arbitration point where no master requests, `grant` becomes zero. A holder that has dropped its request loses the grant at the next arbitration point.
- R10: A `cfg_load` pulse captures `cfg_weights`. Weight k sits in bits `[4k+3:4k]`. The captured weights become active on the clock edge that follows `IDLE_CYCLES` (default 10) consecutive cycles with `req` all zero. Any request restarts that count. `cfg_ok` is high for exactly the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 6 | Per-master request; bits 0..1 processor masters, bits 2..5 round-robin masters |
| lock | input | 6 | Per-master locked-sequence indication |
| xfer_end | input | 1 | The transfer on the shared port completes this cycle |
| cfg_load | input | 1 | Capture `cfg_weights` as pending configuration |
| cfg_weights | input | 16 | Requested weights, 4 bits per round-robin master |
| grant | output | 6 | One-hot grant or zero |
| cfg_ok | output | 1 | One-cycle pulse when pending weights take effect |

## Verification
The bench goes after four kinds of corner case.

- **Rotation wrap-around and skipping.** A design with an off-by-one pointer would regrant the master it just served, or jump past the next requester.
- **A weight of three and a weight of zero placed next to each other.** A miscounting design gives too few or too many transfers, and a design that takes zero literally never grants that master.
- **A locked round-robin holder facing a processor request.** A design that checks priority before lock would break the locked sequence.
- **A configuration window interrupted by a single request.** A design that does not restart the idle count applies the weights too early. It also confirms that `cfg_ok` is a single pulse, and that holding `xfer_end` low freezes the grant.

// File: rtl/wrr_pkg.sv
// Package: shared types for the weighted round-robin arbiter.
// Assumes nothing beyond IEEE 1800-2017.
package wrr_pkg;

    // Outcome of one arbitration decision.
    typedef enum logic [2:0] {
        PICK_HOLD,    // not an arbitration point, grant frozen
        PICK_LOCK,    // locked holder keeps the port
        PICK_PRIO,    // processor master by fixed priority
        PICK_STAY,    // round-robin holder still has weight left
        PICK_ROTATE,  // round-robin rotation to next requester
        PICK_NONE     // nobody requests, release the port
    } pick_e;

endpackage

// File: rtl/wrr_prio_pick.sv
// Module: wrr_prio_pick
// Fixed-priority selector: lowest requesting index wins.
// Assumes: purely combinational, N >= 1.
module wrr_prio_pick #(
    parameter int N = 2
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [N-1:0] onehot
);

    // Scan from top down so the lowest index is written last and wins.
    always_comb begin
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                onehot    = '0;
                onehot[i] = 1'b1;
            end
        end
    end

    // Any request present.
    assign found = |req;

endmodule

// File: rtl/wrr_rr_pick.sv
// Module: wrr_rr_pick
// Rotating selector: finds the first requester after index `last`,
// ascending with wrap-around; `last` itself is tried last.
// Assumes: last < N, purely combinational.
module wrr_rr_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] last,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    localparam int SUM_W = IDX_W + 1;

    logic [IDX_W-1:0] cand [N];

    // Candidate index for each search offset 1..N, reduced modulo N.
    for (genvar k = 0; k < N; k++) begin : g_cand
        logic [SUM_W-1:0] sum;
        assign sum     = SUM_W'(last) + SUM_W'(k + 1);
        assign cand[k] = (sum >= SUM_W'(N)) ? IDX_W'(sum - SUM_W'(N)) : IDX_W'(sum);
    end

    // Walk offsets from far to near so the nearest requester is kept.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[cand[k]]) begin
                found = 1'b1;
                idx   = cand[k];
            end
        end
    end

endmodule

// File: rtl/wrr_cfg_gate.sv
// Module: wrr_cfg_gate
// Holds the active round-robin weights. A load strobe captures new
// weights as pending. They are applied once the bus has had IDLE_CYCLES
// consecutive request-free cycles. Any request restarts the count.
// Assumes: bus_idle is high in cycles where no master requests.
module wrr_cfg_gate #(
    parameter int N_RR        = 4,
    parameter int WEIGHT_W    = 4,
    parameter int IDLE_CYCLES = 10,
    parameter int RST_WEIGHT  = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_idle,
    input  logic                     cfg_load,
    input  logic [N_RR*WEIGHT_W-1:0] cfg_weights,
    output logic [N_RR*WEIGHT_W-1:0] act_weights,
    output logic                     cfg_ok
);

    localparam int WS_W  = N_RR * WEIGHT_W;
    localparam int IDL_W = $clog2(IDLE_CYCLES + 1);

    logic [WS_W-1:0]  shadow_q;
    logic             pend_q;
    logic [IDL_W-1:0] idle_q;
    logic             apply;

    // Pending weights reach the active set once the idle window is full.
    assign apply = pend_q && (idle_q == IDL_W'(IDLE_CYCLES)) && !cfg_load;

    // Count consecutive idle cycles, saturating at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (!bus_idle) begin
            idle_q <= '0;
        end else if (idle_q != IDL_W'(IDLE_CYCLES)) begin
            idle_q <= idle_q + IDL_W'(1);
        end
    end

    // Capture requested weights and track whether an update is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            pend_q   <= 1'b0;
        end else if (cfg_load) begin
            shadow_q <= cfg_weights;
            pend_q   <= 1'b1;
        end else if (apply) begin
            pend_q   <= 1'b0;
        end
    end

    // Active weights and the one-cycle acceptance flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_weights <= {N_RR{WEIGHT_W'(RST_WEIGHT)}};
            cfg_ok      <= 1'b0;
        end else begin
            cfg_ok <= apply;
            if (apply) begin
                act_weights <= shadow_q;
            end
        end
    end

endmodule

// File: rtl/wrr_prio_arbiter.sv
// Module: wrr_prio_arbiter (top)
// Grants one shared slave port. Processor masters (low indices) win by
// fixed priority. The remaining masters share the port by weighted round
// robin, where the weight counts whole transfers. A locked holder keeps
// the port. Weight updates wait for an idle window.
// Assumes: xfer_end marks the cycle in which the current transfer on the
// port completes; the grant is registered and moves only at such a
// boundary or while nobody holds the port.
module wrr_prio_arbiter #(
    parameter int N_PRIO      = 2,
    parameter int N_RR        = 4,
    parameter int WEIGHT_W    = 4,
    parameter int IDLE_CYCLES = 10,
    parameter int RST_WEIGHT  = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_PRIO+N_RR-1:0]   req,
    input  logic [N_PRIO+N_RR-1:0]   lock,
    input  logic                     xfer_end,
    input  logic                     cfg_load,
    input  logic [N_RR*WEIGHT_W-1:0] cfg_weights,
    output logic [N_PRIO+N_RR-1:0]   grant,
    output logic                     cfg_ok
);

    import wrr_pkg::*;

    localparam int N_MST    = N_PRIO + N_RR;
    localparam int RR_IDX_W = (N_RR > 1) ? $clog2(N_RR) : 1;
    localparam int WS_W     = N_RR * WEIGHT_W;

    logic [N_MST-1:0]    grant_q;
    logic [WEIGHT_W-1:0] cnt_q;
    logic [RR_IDX_W-1:0] rr_last_q;

    logic [WS_W-1:0]     act_w;
    logic                prio_found;
    logic [N_PRIO-1:0]   prio_oh;
    logic                rr_found;
    logic [RR_IDX_W-1:0] rr_idx;
    logic [WEIGHT_W-1:0] w_raw;
    logic [WEIGHT_W-1:0] w_eff;
    logic                arb_point;
    logic                holder_locked;
    logic                holder_rr_stay;
    pick_e               pick;

    // Weight store with idle-window update gate.
    wrr_cfg_gate #(
        .N_RR        (N_RR),
        .WEIGHT_W    (WEIGHT_W),
        .IDLE_CYCLES (IDLE_CYCLES),
        .RST_WEIGHT  (RST_WEIGHT)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_idle    (req == '0),
        .cfg_load    (cfg_load),
        .cfg_weights (cfg_weights),
        .act_weights (act_w),
        .cfg_ok      (cfg_ok)
    );

    // Fixed-priority choice among processor masters.
    wrr_prio_pick #(
        .N      (N_PRIO)
    ) u_prio (
        .req    (req[N_PRIO-1:0]),
        .found  (prio_found),
        .onehot (prio_oh)
    );

    // Rotating choice among round-robin masters.
    wrr_rr_pick #(
        .N     (N_RR),
        .IDX_W (RR_IDX_W)
    ) u_rr (
        .req   (req[N_MST-1:N_PRIO]),
        .last  (rr_last_q),
        .found (rr_found),
        .idx   (rr_idx)
    );

    // Weight of the rotation candidate, with zero read as one.
    assign w_raw = act_w[rr_idx*WEIGHT_W +: WEIGHT_W];
    assign w_eff = (w_raw == '0) ? WEIGHT_W'(1) : w_raw;

    // Holder state used by the decision.
    assign arb_point      = xfer_end || (grant_q == '0);
    assign holder_locked  = |(grant_q & lock & req);
    assign holder_rr_stay = (|(grant_q[N_MST-1:N_PRIO] & req[N_MST-1:N_PRIO]))
                            && (cnt_q > WEIGHT_W'(1));

    // Arbitration decision in precedence order.
    always_comb begin
        if (!arb_point)          pick = PICK_HOLD;
        else if (holder_locked)  pick = PICK_LOCK;
        else if (prio_found)     pick = PICK_PRIO;
        else if (holder_rr_stay) pick = PICK_STAY;
        else if (rr_found)       pick = PICK_ROTATE;
        else                     pick = PICK_NONE;
    end

    // Grant, weight counter and rotation pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q   <= '0;
            cnt_q     <= '0;
            rr_last_q <= RR_IDX_W'(N_RR - 1);
        end else begin
            case (pick)
                PICK_PRIO: begin
                    grant_q <= {{N_RR{1'b0}}, prio_oh};
                end
                PICK_STAY: begin
                    cnt_q <= cnt_q - WEIGHT_W'(1);
                end
                PICK_ROTATE: begin
                    grant_q   <= {N_RR'(1) << rr_idx, {N_PRIO{1'b0}}};
                    cnt_q     <= w_eff;
                    rr_last_q <= rr_idx;
                end
                PICK_NONE: begin
                    grant_q <= '0;
                end
                default: begin
                    grant_q <= grant_q;
                end
            endcase
        end
    end

    assign grant = grant_q;

endmodule

// File: rtl/wrr_prio_arbiter_chk.sv
// Module: wrr_prio_arbiter_chk
// Property checker for wrr_prio_arbiter, attached by bind.
// Assumes: only port-level signals of the arbiter are observed.
module wrr_prio_arbiter_chk #(
    parameter int N_PRIO = 2,
    parameter int N_RR   = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_PRIO+N_RR-1:0] req,
    input logic [N_PRIO+N_RR-1:0] lock,
    input logic                   xfer_end,
    input logic [N_PRIO+N_RR-1:0] grant,
    input logic                   cfg_ok
);

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (grant == '0 && !cfg_ok)); // R1

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant)); // R2

    AST_PRIO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((|req[N_PRIO-1:0]) && (xfer_end || grant == '0) && !(|(grant & lock & req)))
        |=> (|grant[N_PRIO-1:0])); // R3

    AST_LOCK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(grant & lock & req)) |=> (grant == $past(grant))); // R7

    AST_FROZEN_MID_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && !xfer_end) |=> $stable(grant)); // R8

    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((xfer_end || grant == '0) && req == '0) |=> (grant == '0)); // R9

    AST_CFG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ok |=> !cfg_ok); // R10

    AST_CFG_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ok |-> ($past(req, 2) == '0)); // R10

endmodule

bind wrr_prio_arbiter wrr_prio_arbiter_chk #(
    .N_PRIO (N_PRIO),
    .N_RR   (N_RR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .lock     (lock),
    .xfer_end (xfer_end),
    .grant    (grant),
    .cfg_ok   (cfg_ok)
);

// File: tb/test_wrr_prio_arbiter.sv
// Bench for wrr_prio_arbiter: a vector table with default weights,
// then directed tests for reset, weights, configuration gating and lock.
module test_wrr_prio_arbiter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  req;
    logic [5:0]  lock;
    logic        xfer_end;
    logic        cfg_load;
    logic [15:0] cfg_weights;
    logic [5:0]  grant;
    logic        cfg_ok;

    int n_chk  = 0;
    int n_fail = 0;

    wrr_prio_arbiter i_wrr_prio_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .lock        (lock),
        .xfer_end    (xfer_end),
        .cfg_load    (cfg_load),
        .cfg_weights (cfg_weights),
        .grant       (grant),
        .cfg_ok      (cfg_ok)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Fields: req, lock, xfer_end, expected grant after the edge.
    localparam logic [18:0] VEC [0:15] = '{
        {6'b000000, 6'b0, 1'b1, 6'b000000},  // R9 nobody requests
        {6'b111100, 6'b0, 1'b1, 6'b000100},  // R5 first pick rr0
        {6'b111100, 6'b0, 1'b1, 6'b001000},  // R4 weight 1 rotates
        {6'b111100, 6'b0, 1'b0, 6'b001000},  // R8 frozen mid transfer
        {6'b111100, 6'b0, 1'b1, 6'b010000},  // R5
        {6'b111100, 6'b0, 1'b1, 6'b100000},  // R5
        {6'b111100, 6'b0, 1'b1, 6'b000100},  // R5 wrap
        {6'b101000, 6'b0, 1'b1, 6'b001000},  // R9 holder dropped
        {6'b101010, 6'b0, 1'b1, 6'b000010},  // R3 processor wins
        {6'b101011, 6'b0, 1'b1, 6'b000001},  // R3 lowest index
        {6'b101011, 6'b0, 1'b0, 6'b000001},  // R8
        {6'b101000, 6'b0, 1'b1, 6'b100000},  // R5 skip rr2
        {6'b101000, 6'b0, 1'b1, 6'b001000},  // R5 wrap skip rr0
        {6'b000000, 6'b0, 1'b1, 6'b000000},  // R9
        {6'b001000, 6'b0, 1'b0, 6'b001000},  // R8 grant zero arbitrates
        {6'b001000, 6'b0, 1'b1, 6'b001000}   // R5 sole requester again
    };

    // Compare and count one check.
    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One clock: inputs already set at the falling edge; sample after rise.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Set inputs at the falling edge.
    task automatic drive(input logic [5:0] r, input logic [5:0] l, input logic x);
        @(negedge clk);
        req      = r;
        lock     = l;
        xfer_end = x;
    endtask

    // Synchronous reset for three cycles.
    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        req      = '0;
        lock     = '0;
        xfer_end = 1'b1;
        cfg_load = 1'b0;
        repeat (3) step();
        chk("R1 grant in reset", 16'(grant), 16'h0);
        chk("R1 cfg_ok in reset", 16'(cfg_ok), 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog.
    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        req         = '0;
        lock        = '0;
        xfer_end    = 1'b1;
        cfg_load    = 1'b0;
        cfg_weights = '0;
        do_reset();
        chk("R1 grant after reset", 16'(grant), 16'h0);

        // Table walk with reset weights of 1: R2 R3 R4 R5 R8 R9.
        for (int i = 0; i < 16; i++) begin
            drive(VEC[i][18:13], VEC[i][12:7], VEC[i][6]);
            step();
            chk($sformatf("R2/R3/R4/R5/R8/R9 row %0d", i), 16'(grant), 16'(VEC[i][5:0]));
        end

        // R10: load weights rr3=1 rr2=2 rr1=0 rr0=3, interrupt the idle window once.
        do_reset();
        @(negedge clk);
        cfg_weights = {4'd1, 4'd2, 4'd0, 4'd3};
        cfg_load    = 1'b1;
        step();
        @(negedge clk);
        cfg_load = 1'b0;
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R10 no apply before window", 16'(cfg_ok), 16'h0);
        end
        drive(6'b000001, 6'b0, 1'b1);
        step();
        chk("R3 processor grant", 16'(grant), 16'h01);
        drive(6'b000000, 6'b0, 1'b1);
        for (int i = 0; i < 10; i++) begin
            step();
            chk("R10 window restarted by request", 16'(cfg_ok), 16'h0);
        end
        step();
        chk("R10 cfg_ok after full idle window", 16'(cfg_ok), 16'h1);
        step();
        chk("R10 cfg_ok single pulse", 16'(cfg_ok), 16'h0);

        // R4 R6 R5: weights 3,0,2,1 with all round-robin masters requesting.
        begin
            logic [5:0] exp_seq [8];
            exp_seq = '{6'h04, 6'h04, 6'h04, 6'h08, 6'h10, 6'h10, 6'h20, 6'h04};
            drive(6'b111100, 6'b0, 1'b1);
            for (int i = 0; i < 8; i++) begin
                step();
                chk($sformatf("R4/R6 weighted step %0d", i), 16'(grant), 16'(exp_seq[i]));
            end
        end

        // R7: locked round-robin holder beats processors and its used weight.
        drive(6'b111111, 6'b000100, 1'b1);
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R7 locked holder keeps grant", 16'(grant), 16'h04);
        end
        drive(6'b111111, 6'b000000, 1'b1);
        step();
        chk("R3 priority after unlock", 16'(grant), 16'h01);
        drive(6'b111111, 6'b000001, 1'b1);
        repeat (2) begin
            step();
            chk("R7 locked processor keeps grant", 16'(grant), 16'h01);
        end
        drive(6'b000010, 6'b000000, 1'b1);
        step();
        chk("R3 next processor", 16'(grant), 16'h02);

        // R3: continuous processor request starves round-robin masters.
        drive(6'b111110, 6'b0, 1'b1);
        for (int i = 0; i < 6; i++) begin
            step();
            chk("R3 starvation preserved", 16'(grant), 16'h02);
        end
        drive(6'b000000, 6'b0, 1'b1);
        step();
        chk("R9 release", 16'(grant), 16'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule